// File: doc/BRIEF.md
# Boot Strap Capture and Reset Sequencer

This block sits at the root of a switch device's reset tree. It watches the asynchronous, active-low fundamental reset pin. When the pin is released, it takes one snapshot of the configuration strap pins and keeps that snapshot as a status word. It then counts the core out of reset. Three outputs carry the result: a core reset, a separate reset for sticky register fields, and an enable for the management buses.

Two straps change the release path. When the snapshot selects the mode with serial EEPROM initialisation, the core stays in reset until the loader reports that it is done. When the halt strap is captured high, the sequence finishes but parks with the management buses enabled and the core still in reset. The core is released only when software clears the halt bit. A hot reset request puts the core back through the counted reset and leaves sticky state and the snapshot alone. A fundamental reset, whether cold (`rst_ni`) or warm (the pin alone), clears everything.

Top module: `boot_strap_ctrl`

## Requirements
- R1: After the synchronised fundamental reset pin reads low, the next clock edge asserts the core reset and the sticky reset (`core_rst_no` = 0, `sticky_rst_no` = 0) and drops `mgmt_en_o`. The controller reaches the same state out of `rst_ni`.
- R2: On the clock edge after the synchronised pin reads high, the straps are captured into `strap_status_o`. The layout is bits [2:0] switch mode, bit 3 reference clock select (1 = 125 MHz, 0 = 100 MHz), bit 4 halt, bit 5 common clock upstream, bit 6 common clock downstream, bit 7 management bus slow mode.
- R3: Strap pin changes at any time other than the capture edge do not change `strap_status_o`.
- R4: With switch mode 0, halt strap 0 and the default parameters, `core_rst_no` rises exactly SYNC_STAGES+1+RELEASE_CYCLES = 19 clock edges after the pin is released. `mgmt_en_o` and `sticky_rst_no` are high from the capture edge onward.
- R5: With captured switch mode 1, `eeprom_init_o` is 1, and `core_rst_no` stays low after the count until `eeprom_done_i` is sampled high. It rises on that same edge.
- R6: Captured switch modes 2 to 7 appear unchanged in `strap_status_o[2:0]` but act as mode 0: `eeprom_init_o` is 0, and `eeprom_done_i` does not delay release.
- R7: With the halt strap captured high, `halt_o` is 1. `core_rst_no` stays low while `mgmt_en_o` and `sticky_rst_no` stay high, until `halt_clr_i` is sampled high. `core_rst_no` rises on that edge, and `halt_o` falls.
- R8: While the core runs, a `hot_rst_i` sampled high drops `core_rst_no` at that edge. The core is released RELEASE_CYCLES = 16 edges after the last edge with `hot_rst_i` high. `sticky_rst_no`, `mgmt_en_o` and `strap_status_o` do not change.
- R9: A warm fundamental reset (pin low, `rst_ni` high) asserts the sticky reset, and the following release captures the new strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Cold power-on reset, active low, asynchronous |
| fund_rst_ni | input | 1 | Fundamental reset pin, active low, asynchronous to clk_i |
| hot_rst_i | input | 1 | Hot reset request, synchronous |
| mode_strap_i | input | 3 | Switch mode strap |
| refclk_strap_i | input | 1 | Reference clock select strap |
| halt_strap_i | input | 1 | Reset halt strap |
| cclk_up_strap_i | input | 1 | Common clock upstream strap |
| cclk_dn_strap_i | input | 1 | Common clock downstream strap |
| smb_slow_strap_i | input | 1 | Management bus slow mode strap |
| eeprom_done_i | input | 1 | EEPROM loader finished |
| halt_clr_i | input | 1 | Software clear of the halt bit, one-cycle pulse |
| core_rst_no | output | 1 | Core reset, active low |
| sticky_rst_no | output | 1 | Sticky field reset, active low |
| mgmt_en_o | output | 1 | Management bus enable |
| eeprom_init_o | output | 1 | Captured mode requests EEPROM initialisation |
| halt_o | output | 1 | Halt bit |
| strap_status_o | output | 8 | Captured strap word |

## Verification
The pin passes through two synchroniser flops before the capture register, so the status word is due three edges after the pin rises. Core release is due SYNC_STAGES+1+RELEASE_CYCLES edges after the pin rises. Release after a halt clear or an EEPROM done comes on the edge that samples the input, and release after a hot reset comes RELEASE_CYCLES edges after the request is sampled. The bench drives every input on a falling edge and counts rising edges from that point. It checks each output one edge before its due cycle, where the old value must still hold, and on the due cycle itself, so a release one cycle early or late fails.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    ST_FUND, ST_WAIT, ST_EEP, ST_HALT, ST_RUN, ST_HOT
  } seq_state_e;

  typedef struct packed {
    logic       smb_slow;
    logic       cclk_dn;
    logic       cclk_up;
    logic       halt;
    logic       refclk_125;
    logic [2:0] mode;
  } strap_t;

  localparam logic [2:0] MODE_EEPROM = 3'd1;
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/bsc_strap_latch.sv
module bsc_strap_latch
  import bsc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cap_i,
  input  strap_t strap_i,
  output strap_t status_o,
  output logic   eep_mode_o
);
  strap_t status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= '0;
    else if (cap_i) status_q <= strap_i;
  end

  assign status_o   = status_q;
  // reserved codes fall back to plain mode
  assign eep_mode_o = (status_q.mode == MODE_EEPROM);
endmodule

// File: rtl/bsc_seq.sv
module bsc_seq
  import bsc_pkg::*;
#(
  parameter int RELEASE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fund_ok_i,
  input  logic halt_strap_i,
  input  logic eep_mode_i,
  input  logic eeprom_done_i,
  input  logic halt_clr_i,
  input  logic hot_rst_i,
  output logic cap_o,
  output logic core_rst_no,
  output logic sticky_rst_no,
  output logic mgmt_en_o,
  output logic halt_o
);
  localparam int CW = $clog2(RELEASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

  seq_state_e state_q, state_d, post_eep;
  logic [CW-1:0] cnt_q;
  logic halt_q;

  assign cap_o = (state_q == ST_FUND) && fund_ok_i;

  always_comb begin
    post_eep = (halt_q && !halt_clr_i) ? ST_HALT : ST_RUN;
    state_d  = state_q;
    unique case (state_q)
      ST_FUND: if (fund_ok_i) state_d = ST_WAIT;
      ST_WAIT: if (cnt_q == LAST)
                 state_d = (eep_mode_i && !eeprom_done_i) ? ST_EEP : post_eep;
      ST_EEP:  if (eeprom_done_i) state_d = post_eep;
      ST_HALT: if (halt_clr_i || !halt_q) state_d = ST_RUN;
      ST_RUN:  if (hot_rst_i) state_d = ST_HOT;
      ST_HOT:  if (!hot_rst_i && cnt_q == LAST) state_d = ST_RUN;
      default: state_d = ST_FUND;
    endcase
    if (!fund_ok_i) state_d = ST_FUND;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FUND;
      cnt_q   <= '0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == state_q && (state_q == ST_WAIT ||
          (state_q == ST_HOT && !hot_rst_i)))
        cnt_q <= cnt_q + 1'b1;
      else
        cnt_q <= '0;
      if (cap_o)           halt_q <= halt_strap_i;
      else if (halt_clr_i) halt_q <= 1'b0;
    end
  end

  assign core_rst_no   = (state_q == ST_RUN);
  assign sticky_rst_no = (state_q != ST_FUND);
  assign mgmt_en_o     = (state_q != ST_FUND);
  assign halt_o        = halt_q;

  assert_fund_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fund_ok_i |=> (!sticky_rst_no && !core_rst_no && !mgmt_en_o));
  assert_eep_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EEP && !eeprom_done_i && fund_ok_i) |=> !core_rst_no);
  assert_halt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && halt_q && !halt_clr_i && fund_ok_i)
      |=> (!core_rst_no && mgmt_en_o));
  assert_hot_keeps_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_no && hot_rst_i && fund_ok_i) |=> (!core_rst_no && sticky_rst_no));
endmodule

// File: rtl/boot_strap_ctrl.sv
module boot_strap_ctrl
  import bsc_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int RELEASE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fund_rst_ni,
  input  logic       hot_rst_i,
  input  logic [2:0] mode_strap_i,
  input  logic       refclk_strap_i,
  input  logic       halt_strap_i,
  input  logic       cclk_up_strap_i,
  input  logic       cclk_dn_strap_i,
  input  logic       smb_slow_strap_i,
  input  logic       eeprom_done_i,
  input  logic       halt_clr_i,
  output logic       core_rst_no,
  output logic       sticky_rst_no,
  output logic       mgmt_en_o,
  output logic       eeprom_init_o,
  output logic       halt_o,
  output logic [7:0] strap_status_o
);
  logic   fund_ok, cap;
  strap_t strap_in, status;

  assign strap_in = '{smb_slow: smb_slow_strap_i, cclk_dn: cclk_dn_strap_i,
                      cclk_up: cclk_up_strap_i, halt: halt_strap_i,
                      refclk_125: refclk_strap_i, mode: mode_strap_i};

  bsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fund_rst_ni), .q_o(fund_ok)
  );

  bsc_strap_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .strap_i(strap_in),
    .status_o(status), .eep_mode_o(eeprom_init_o)
  );

  bsc_seq #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .fund_ok_i(fund_ok),
    .halt_strap_i(halt_strap_i), .eep_mode_i(eeprom_init_o),
    .eeprom_done_i(eeprom_done_i), .halt_clr_i(halt_clr_i),
    .hot_rst_i(hot_rst_i), .cap_o(cap), .core_rst_no(core_rst_no),
    .sticky_rst_no(sticky_rst_no), .mgmt_en_o(mgmt_en_o), .halt_o(halt_o)
  );

  assign strap_status_o = status;

  assert_status_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(strap_status_o));
  assert_status_cold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sticky_rst_no |-> !core_rst_no);
endmodule

// File: tb/boot_strap_ctrl_bench.sv
`timescale 1ns/1ps
module boot_strap_ctrl_bench;
  localparam int S   = 2;
  localparam int R   = 16;
  localparam int LAT = S + 1 + R;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, fund_rst_ni = 1'b0, hot_rst_i = 1'b0;
  logic [2:0] mode_strap_i = '0;
  logic refclk_strap_i = 1'b0, halt_strap_i = 1'b0, cclk_up_strap_i = 1'b0;
  logic cclk_dn_strap_i = 1'b0, smb_slow_strap_i = 1'b0;
  logic eeprom_done_i = 1'b0, halt_clr_i = 1'b0;
  logic core_rst_no, sticky_rst_no, mgmt_en_o, eeprom_init_o, halt_o;
  logic [7:0] strap_status_o;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  boot_strap_ctrl #(.SYNC_STAGES(S), .RELEASE_CYCLES(R)) u_boot_strap_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .fund_rst_ni(fund_rst_ni), .hot_rst_i(hot_rst_i),
    .mode_strap_i(mode_strap_i), .refclk_strap_i(refclk_strap_i),
    .halt_strap_i(halt_strap_i), .cclk_up_strap_i(cclk_up_strap_i),
    .cclk_dn_strap_i(cclk_dn_strap_i), .smb_slow_strap_i(smb_slow_strap_i),
    .eeprom_done_i(eeprom_done_i), .halt_clr_i(halt_clr_i),
    .core_rst_no(core_rst_no), .sticky_rst_no(sticky_rst_no),
    .mgmt_en_o(mgmt_en_o), .eeprom_init_o(eeprom_init_o), .halt_o(halt_o),
    .strap_status_o(strap_status_o)
  );

  function automatic logic [7:0] pack_straps();
    return {smb_slow_strap_i, cclk_dn_strap_i, cclk_up_strap_i, halt_strap_i,
            refclk_strap_i, mode_strap_i};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_straps(logic [7:0] v);
    {smb_slow_strap_i, cclk_dn_strap_i, cclk_up_strap_i, halt_strap_i,
     refclk_strap_i, mode_strap_i} = v;
  endtask

  // pull pin low, check reset state, release with straps v; ends on due edge of release
  task automatic fund_cycle(logic [7:0] v);
    fund_rst_ni = 1'b0;
    step(S + 1);
    chk("R1 core", 32'(core_rst_no), 0);
    chk("R1 sticky/R9", 32'(sticky_rst_no), 0);
    chk("R1 mgmt", 32'(mgmt_en_o), 0);
    set_straps(v);
    fund_rst_ni = 1'b1;
    step(S + 1);
    chk("R2 status", 32'(strap_status_o), 32'(v));
    chk("R4 mgmt", 32'(mgmt_en_o), 1);
    step(R - 1);
    chk("R4 core early", 32'(core_rst_no), 0);
    step(1);
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v, held;
    void'($urandom(32'h5eed_0042));
    step(2);
    chk("R1 cold core", 32'(core_rst_no), 0);
    chk("R1 cold sticky", 32'(sticky_rst_no), 0);
    chk("R2 cold status", 32'(strap_status_o), 0);
    rst_ni = 1'b1;
    eeprom_done_i = 1'b1;

    // directed plain boot
    fund_cycle(8'b1010_1000);
    chk("R4 core release", 32'(core_rst_no), 1);
    chk("R4 sticky", 32'(sticky_rst_no), 1);

    // R3: strap wiggle while running
    held = strap_status_o;
    set_straps(8'hFF);
    step(5);
    chk("R3 status frozen", 32'(strap_status_o), 32'(held));

    // R8: hot reset
    hot_rst_i = 1'b1;
    step(1);
    hot_rst_i = 1'b0;
    chk("R8 core in hot", 32'(core_rst_no), 0);
    chk("R8 sticky kept", 32'(sticky_rst_no), 1);
    chk("R8 mgmt kept", 32'(mgmt_en_o), 1);
    step(R - 1);
    chk("R8 core early", 32'(core_rst_no), 0);
    chk("R8 status kept", 32'(strap_status_o), 32'(held));
    step(1);
    chk("R8 core release", 32'(core_rst_no), 1);

    // R5: EEPROM mode waits for done
    eeprom_done_i = 1'b0;
    fund_cycle(8'h01);
    chk("R5 eeprom mode", 32'(eeprom_init_o), 1);
    chk("R5 core held", 32'(core_rst_no), 0);
    step(7);
    chk("R5 core still held", 32'(core_rst_no), 0);
    eeprom_done_i = 1'b1;
    step(1);
    chk("R5 core release", 32'(core_rst_no), 1);

    // R6: reserved mode, done low does not delay
    eeprom_done_i = 1'b0;
    fund_cycle(8'h06);
    chk("R6 raw mode", 32'(strap_status_o[2:0]), 6);
    chk("R6 no eeprom", 32'(eeprom_init_o), 0);
    chk("R6 core release", 32'(core_rst_no), 1);
    eeprom_done_i = 1'b1;

    // R7: halt
    fund_cycle(8'h10);
    chk("R7 halt bit", 32'(halt_o), 1);
    chk("R7 core held", 32'(core_rst_no), 0);
    step(9);
    chk("R7 core still held", 32'(core_rst_no), 0);
    chk("R7 mgmt on", 32'(mgmt_en_o), 1);
    chk("R7 sticky off", 32'(sticky_rst_no), 1);
    halt_clr_i = 1'b1;
    step(1);
    halt_clr_i = 1'b0;
    chk("R7 core release", 32'(core_rst_no), 1);
    chk("R7 halt cleared", 32'(halt_o), 0);

    // random warm resets (R9)
    for (int i = 0; i < 12; i++) begin
      logic exp_eep, exp_halt;
      v = 8'($urandom);
      exp_eep  = (v[2:0] == 3'd1);
      exp_halt = v[4];
      fund_cycle(v);
      chk("R9 recapture", 32'(strap_status_o), 32'(v));
      chk("R5/R6 eeprom flag", 32'(eeprom_init_o), 32'(exp_eep));
      chk("R7 halt flag", 32'(halt_o), 32'(exp_halt));
      chk("R4/R7 release", 32'(core_rst_no), 32'(!exp_halt));
      if (exp_halt) begin
        step(1 + ($urandom % 6));
        chk("R7 held", 32'(core_rst_no), 0);
        halt_clr_i = 1'b1;
        step(1);
        halt_clr_i = 1'b0;
        chk("R7 release", 32'(core_rst_no), 1);
      end
      set_straps(8'($urandom));
      step(3);
      chk("R3 frozen", 32'(strap_status_o), 32'(v));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule